// File: doc/BRIEF.md
# MDIO Management Master with Single Command Register

This block carries out Clause-22 management transactions toward external PHYs and is driven through one 32-bit command/status word. Software launches a transaction by writing a single word. That word packs the launch flags, the opcode, the PHY and register addresses and, for a write, 16 data bits. The block then generates MDC and shifts one complete 64-bit frame on MDIO. It releases the data line while the PHY answers a read. When the frame ends, it clears the busy flag on its own.

The command word can be read back at any time. After a read finishes, its low 16 bits hold the value the PHY returned. Software is expected to poll the busy flag and issue the next command only after it clears. A word written while a frame is in flight has no effect. MDIO appears as separate output, output-enable and input pins, which are joined by a tristate pad outside the block.

Top module: `mdio_mgmt_master`

## Requirements
- R1: A write whose bit 31 (access) and bit 16 (start) are both 1, and in which exactly one of bit 19 (read) and bit 18 (write) is 1, launches a frame. Bit 31 of the readback word is 1 from the following cycle.
- R2: The frame is sent MSB first, sampled on rising MDC. It consists of 32 ones, then 01, then opcode 10 for a read or 01 for a write, then the PHY address from bits 24:20, then the register address from bits 29:25.
- R3: In a write frame, the turnaround is driven as 10 and is followed by command bits 15:0. The output enable stays 1 for all 64 bits.
- R4: In a read frame, the output enable is 0 for bit positions 46..63, which are the turnaround and the data. The 16 bits the PHY presents at rising MDC in positions 48..63 are returned in readback bits 15:0, MSB first, once bit 31 has cleared.
- R5: MDC has a period of CLK_DIV system clocks while a frame runs and stays low when idle. MDIO changes only after a falling MDC edge.
- R6: Bit 31 stays 1 for exactly 64*CLK_DIV cycles per frame, then clears by itself.
- R7: A write with bit 31 or bit 16 clear, or with neither or both opcode bits set, starts no frame. The word is stored with bit 31 read back as 0 in the next cycle, and MDC stays low.
- R8: A write made while bit 31 is 1 is ignored. The readback word, the frame on the wire and the returned data are unchanged.
- R9: After reset the readback word is 0, MDC is 0 and the MDIO output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command/status readback; bits 15:0 carry read data |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO drive enable, 1 = block drives |

## Verification
The hardest case to reach from the ports is a second command arriving in the middle of an active frame. That write has to leave the wire sequence, the stored word and the returned read data untouched. The bench covers it by injecting a random word partway through a read frame, then checking the captured frame and the returned data against the original command. A PHY responder in the bench answers reads by driving the pad on falling MDC, counted from the rising edges it has seen. It checks the released bit window and the data alignment bit by bit over randomized addresses and data. Malformed opcode combinations are driven in directed tests, and the bench confirms that MDC never toggles after them.

// File: rtl/mdio_mm_pkg.sv
package mdio_mm_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  localparam int ACC_BIT    = 31;
  localparam int START_BIT  = 16;
  localparam int RD_BIT     = 19;
  localparam int WR_BIT     = 18;
  localparam int PHY_LSB    = 20;
  localparam int REG_LSB    = 25;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;

  // A word launches a frame only with access, start and one opcode bit.
  function automatic logic cmd_launches(input logic [31:0] w);
    return w[ACC_BIT] && w[START_BIT] && (w[RD_BIT] ^ w[WR_BIT]);
  endfunction

  // Full on-wire sequence, MSB first. Read turnaround/data are filler
  // since the line is released there.
  function automatic logic [FRAME_BITS-1:0] make_frame(input logic [31:0] w);
    logic rd;
    rd = w[RD_BIT];
    return {32'hFFFF_FFFF, 2'b01,
            (rd ? 2'b10 : 2'b01),
            w[PHY_LSB +: ADDR_W],
            w[REG_LSB +: ADDR_W],
            (rd ? 2'b11 : 2'b10),
            (rd ? 16'hFFFF : w[DATA_W-1:0])};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = en && (cnt == CW'(HALF - 1));
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: MDC parks low whenever no frame is running
  assert_mdc_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_mm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_rd,
  input  logic [FRAME_BITS-1:0] start_frame,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  mdo,
  output logic                  mdoe,
  output logic                  done,
  output logic [DATA_W-1:0]     rx_data
);
  localparam int IW = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sh;
  logic [IW-1:0]         idx;
  logic                  rd;
  logic                  last_bit;
  logic                  in_data;
  logic                  next_released;

  assign last_bit      = (idx == IW'(FRAME_BITS));
  assign in_data       = rd && (idx >= IW'(DATA_POS));
  assign next_released = rd && (idx >= IW'(TA_POS));
  assign done          = active && fall_tick && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sh      <= '0;
      idx     <= '0;
      rd      <= 1'b0;
      mdo     <= 1'b0;
      mdoe    <= 1'b0;
      rx_data <= '0;
    end else if (start) begin
      active <= 1'b1;
      rd     <= start_rd;
      idx    <= '0;
      mdo    <= start_frame[FRAME_BITS-1];
      sh     <= start_frame << 1;
      mdoe   <= 1'b1;
    end else if (active) begin
      if (rise_tick) begin
        if (in_data) rx_data <= {rx_data[DATA_W-2:0], mdio_i};
        idx <= idx + 1'b1;
      end
      if (fall_tick) begin
        if (last_bit) begin
          active <= 1'b0;
          mdoe   <= 1'b0;
          mdo    <= 1'b0;
        end else begin
          mdo  <= sh[FRAME_BITS-1];
          sh   <= sh << 1;
          mdoe <= !next_released;
        end
      end
    end
  end

  // R3: write frames drive the line throughout
  assert_write_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rd) |-> mdoe);
  // R4: read frames leave the line to the PHY from the turnaround on
  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd && idx > IW'(TA_POS)) |-> !mdoe);
  // R5: data only changes after a falling MDC tick
  assert_mdo_fall_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(fall_tick)) |-> $stable(mdo));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mm_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [31:0]       cmd_q;
  logic              busy;
  logic              launch;
  logic              accept;
  logic              frame_active;
  logic              frame_done;
  logic              rise_tick;
  logic              fall_tick;
  logic [DATA_W-1:0] rx_data;

  assign busy      = cmd_q[ACC_BIT];
  assign accept    = cmd_we && !busy;
  assign launch    = accept && cmd_launches(cmd_wdata);
  assign cmd_rdata = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (accept) begin
      cmd_q          <= cmd_wdata;
      cmd_q[ACC_BIT] <= launch;
    end else if (frame_done) begin
      cmd_q[ACC_BIT] <= 1'b0;
      if (cmd_q[RD_BIT]) cmd_q[DATA_W-1:0] <= rx_data;
    end
  end

  mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (frame_active),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (launch),
    .start_rd    (cmd_wdata[RD_BIT]),
    .start_frame (make_frame(cmd_wdata)),
    .rise_tick   (rise_tick),
    .fall_tick   (fall_tick),
    .mdio_i      (mdio_i),
    .active      (frame_active),
    .mdo         (mdio_o),
    .mdoe        (mdio_oe),
    .done        (frame_done),
    .rx_data     (rx_data)
  );

  // R1: a well-formed command raises busy and starts the shifter
  assert_launch_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && frame_active));
  // R6: busy holds until the shifter reports the end of the frame
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> busy);
  // R7: a malformed command leaves the block idle
  assert_bad_cmd_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !launch) |=> (!busy && !frame_active));
  // R8: writes during a frame do not alter the stored word
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we && !frame_done) |=> $stable(cmd_rdata));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_bit = 1'b1;

  int checks = 0;
  int errors = 0;

  // bench-side monitor state
  int          rises = 0;
  logic [63:0] cap_o = '0, cap_oe = '0;
  logic [15:0] phy_data = '0;
  int          cyc = 0, last_rise_cyc = 0;
  int          period_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mdio_i = mdio_oe ? mdio_o : phy_bit;

  mdio_mgmt_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  always @(negedge clk) cyc++;

  always @(posedge mdc) begin
    cap_o  = {cap_o[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    if (rises > 0 && (cyc - last_rise_cyc) != DIV) period_bad++;
    last_rise_cyc = cyc;
    rises++;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises <= 63) phy_bit = phy_data[63 - rises];
    else phy_bit = 1'b1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expect_wire(input logic [31:0] w);
    logic [63:0] f;
    f[63:32] = '1;
    f[31:30] = 2'b01;
    f[29:28] = w[19] ? 2'b10 : 2'b01;
    f[27:23] = w[24:20];
    f[22:18] = w[29:25];
    f[17:16] = 2'b10;
    f[15:0]  = w[15:0];
    return f;
  endfunction

  function automatic logic [31:0] make_cmd(input bit rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    logic [31:0] w;
    w = '0;
    w[31] = 1'b1; w[16] = 1'b1;
    if (rd) w[19] = 1'b1; else w[18] = 1'b1;
    w[24:20] = phy; w[29:25] = rg; w[15:0] = d;
    return w;
  endfunction

  // Runs one valid command; optionally injects a write mid-frame.
  task automatic run_cmd(input logic [31:0] w, input logic [15:0] pdata,
                         input bit inject, input logic [31:0] junk);
    int busy_cycles;
    bit rd;
    logic [31:0] exp_rd;
    rd = w[19];
    rises = 0; period_bad = 0; cap_o = '0; cap_oe = '0; phy_data = pdata;
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_we = 1'b0;
    check("R1 busy set", {63'd0, cmd_rdata[31]}, 64'd1);
    busy_cycles = 0;
    while (cmd_rdata[31] && busy_cycles < 100000) begin
      busy_cycles++;
      if (inject && busy_cycles == 70) begin cmd_we = 1'b1; cmd_wdata = junk; end
      @(negedge clk);
      cmd_we = 1'b0;
    end
    check("R6 busy length", 64'(busy_cycles), 64'(64 * DIV));
    check("R5 mdc period", 64'(period_bad), 64'd0);
    check("R5 mdc idle low", {63'd0, mdc}, 64'd0);
    if (rd) begin
      check("R2 read header", {18'd0, cap_o[63:18]}, {18'd0, expect_wire(w) >> 18});
      check("R4 read oe window", cap_oe, {46'h3FFF_FFFF_FFFF, 18'd0});
      exp_rd = {1'b0, w[30:16], pdata};
      check(inject ? "R8 read data after ignored write" : "R4 read data",
            64'(cmd_rdata), 64'(exp_rd));
    end else begin
      check("R3 write frame", cap_o, expect_wire(w));
      check("R3 write oe", cap_oe, '1);
      check(inject ? "R8 word after ignored write" : "R3 readback",
            64'(cmd_rdata), 64'({1'b0, w[30:0]}));
    end
    check("R2 rise count", 64'(rises), 64'd64);
  endtask

  task automatic bad_cmd(input logic [31:0] w, input string req);
    int toggles;
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_we = 1'b0;
    check(req, 64'(cmd_rdata), 64'({1'b0, w[30:0]}));
    toggles = 0;
    for (int i = 0; i < 4 * DIV; i++) begin
      if (mdc) toggles++;
      @(negedge clk);
    end
    check("R7 no mdc activity", 64'(toggles), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R9 reset word", 64'(cmd_rdata), 64'd0);
    check("R9 reset mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_cmd(make_cmd(1'b0, 5'h1F, 5'h1F, 16'hFFFF), 16'h0, 1'b0, '0);
    run_cmd(make_cmd(1'b0, 5'h00, 5'h00, 16'h0000), 16'h0, 1'b0, '0);
    run_cmd(make_cmd(1'b1, 5'h01, 5'h1E, 16'h0000), 16'hA5C3, 1'b0, '0);
    run_cmd(make_cmd(1'b1, 5'h10, 5'h01, 16'h0000), 16'h0001, 1'b0, '0);

    // malformed commands (R7)
    w = make_cmd(1'b1, 5'h3, 5'h4, 16'h1234); w[18] = 1'b1;
    bad_cmd(w, "R7 both opcodes");
    w = make_cmd(1'b1, 5'h3, 5'h4, 16'h1234); w[19] = 1'b0;
    bad_cmd(w, "R7 no opcode");
    w = make_cmd(1'b0, 5'h3, 5'h4, 16'h1234); w[16] = 1'b0;
    bad_cmd(w, "R7 missing start");
    w = make_cmd(1'b0, 5'h3, 5'h4, 16'h1234); w[31] = 1'b0;
    bad_cmd(w, "R7 missing access");

    // writes during a frame (R8)
    run_cmd(make_cmd(1'b1, 5'h05, 5'h0A, 16'h0), 16'h5A5A, 1'b1,
            make_cmd(1'b0, 5'h1A, 5'h15, 16'hDEAD));
    run_cmd(make_cmd(1'b0, 5'h07, 5'h03, 16'hBEEF), 16'h0, 1'b1,
            make_cmd(1'b1, 5'h02, 5'h02, 16'h0000));

    // constrained random traffic
    for (int n = 0; n < 30; n++) begin
      logic [31:0] r;
      r = $urandom;
      run_cmd(make_cmd(r[0], r[5:1], r[10:6], r[31:16]), 16'($urandom), 1'b0, '0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule